// File: doc/BRIEF.md
# Wake-up status pin toggler

This block holds one 8-bit control register that presents a status level on one of two general-purpose port pins. Software sets an output enable, a pin select and a starting level through a small register bus. The bus takes whole-byte writes and single-bit writes, and reads back the register at any time. In hardware the level bit inverts each time the device is released from its deep-sleep state and each time it leaves snooze mode for full run. An external agent watching the pin can therefore count wake-ups without any software running.

While the output is enabled, the selected pin carries the level bit and the other pin keeps its own port-latch value. While it is disabled, both pins pass their port latches through unchanged. An external guard input locks out all register writes. A build-time option removes the pin select: bit 0 is then a reserved read-only zero and the level always goes to pin A.

Top module: `wkst_toggler`

## Requirements
- R1: After reset the register reads 0x00 and each pin equals its own port-latch input.
- R2: A byte write stores bit 7 (enable), bit 4 (level) and bit 0 (select). Bits 1, 2, 3, 5 and 6 always read 0.
- R3: A bit write uses a 3-bit index and a data bit, and changes only the indexed bit. An index that names a reserved bit changes nothing.
- R4: While the guard input is 1, byte and bit writes have no effect on the register. Wake events still invert the level.
- R5: A one-cycle stop-release strobe inverts the level bit on the next clock edge, whether or not the output is enabled.
- R6: A one-cycle snooze-to-run strobe inverts the level bit. If both strobes arrive in the same cycle, that counts as two inversions and the level is unchanged.
- R7: When an accepted write sets the level bit in the same cycle as a wake strobe, the written value wins. A write that does not touch bit 4 leaves the inversion in effect.
- R8: With enable 1 and select 0, pin A follows the level bit and pin B follows its own latch.
- R9: With enable 1 and select 1, pin B follows the level bit and pin A follows its own latch.
- R10: With enable 0, both pins follow their own latches, including after a wake event.
- R11: If a byte write and a bit write arrive in the same cycle, only the byte write is applied.
- R12: With the fixed-select option, bit 0 reads 0, writes to it are ignored, and an enabled level is always driven on pin A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte_en | input | 1 | Byte write strobe |
| wr_byte_data | input | 8 | Byte write data |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_idx | input | 3 | Bit index for a single-bit write |
| wr_bit_val | input | 1 | Data for a single-bit write |
| wr_guard | input | 1 | Global write protect, 1 blocks writes |
| stop_wake | input | 1 | One-cycle strobe on release from deep sleep |
| snooze_wake | input | 1 | One-cycle strobe on snooze-to-run transition |
| latch_a | input | 1 | Port-latch value of pin A |
| latch_b | input | 1 | Port-latch value of pin B |
| rd_data | output | 8 | Register read-back |
| pin_a | output | 1 | Pin A output |
| pin_b | output | 1 | Pin B output |

## Verification
The bench puts a wake strobe in the same cycle as a level write. A design that applied the inversion after the write would read back the opposite level. It also fires both strobes together, where a design that ORs the events would flip the level once. A write attempted under the guard, together with a wake strobe, catches a design that freezes the whole register instead of blocking only the bus. Reserved-index bit writes, colliding byte and bit writes, and the fixed-select variant expose masks that leak reserved or locked bits. The bench also flips the port latches while the output is disabled or steered to the other pin, to catch a mux that drives the wrong pin or drops the latch pass-through.

// File: rtl/wkst_pkg.sv
package wkst_pkg;
   localparam int REG_W   = 8;
   localparam int IDX_W   = $clog2(REG_W);
   localparam int EN_POS  = 7;
   localparam int LVL_POS = 4;
   localparam int SEL_POS = 0;
   localparam int N_PINS  = 2;

   // Bits that hold state; every other bit is reserved and reads zero.
   function automatic logic [REG_W-1:0] wr_mask(input bit sel_fixed);
      logic [REG_W-1:0] m;
      m = '0;
      m[EN_POS]  = 1'b1;
      m[LVL_POS] = 1'b1;
      if (!sel_fixed) m[SEL_POS] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/wkst_ctrl_reg.sv
module wkst_ctrl_reg
   import wkst_pkg::*;
#(
   parameter bit SEL_FIXED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte_en,
   input  logic [REG_W-1:0] wr_byte_data,
   input  logic             wr_bit_en,
   input  logic [IDX_W-1:0] wr_bit_idx,
   input  logic             wr_bit_val,
   input  logic             wr_guard,
   input  logic             stop_wake,
   input  logic             snooze_wake,
   output logic [REG_W-1:0] reg_q
);
   localparam logic [REG_W-1:0] WMASK   = wr_mask(SEL_FIXED);
   localparam logic [IDX_W-1:0] LVL_IDX = IDX_W'(LVL_POS);

   initial begin
      assert (EN_POS < REG_W && LVL_POS < REG_W && SEL_POS < REG_W)
         else $error("field position outside register");
      assert (EN_POS != LVL_POS && LVL_POS != SEL_POS && EN_POS != SEL_POS)
         else $error("field positions overlap");
   end

   logic [REG_W-1:0] nxt;
   logic             lvl_by_sw;
   logic             flip;

   always_comb begin
      nxt       = reg_q;
      lvl_by_sw = 1'b0;
      if (!wr_guard) begin
         if (wr_byte_en) begin
            nxt       = wr_byte_data & WMASK;
            lvl_by_sw = 1'b1;
         end else if (wr_bit_en) begin
            nxt[wr_bit_idx] = wr_bit_val;
            nxt             = nxt & WMASK;
            lvl_by_sw       = (wr_bit_idx == LVL_IDX);
         end
      end
      // Two events in one cycle cancel: each is an inversion.
      flip = stop_wake ^ snooze_wake;
      if (flip && !lvl_by_sw) nxt[LVL_POS] = ~reg_q[LVL_POS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= nxt;
   end

   // R2: reserved and locked bits never hold a one
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_q & ~WMASK) == '0);

   // R4: guarded cycle without net wake event leaves the register intact
   assert_guard_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_guard && (stop_wake == snooze_wake)) |=> $stable(reg_q));

   // R5: stop release alone with no level write inverts the level
   assert_stop_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_wake && !snooze_wake && (wr_guard || (!wr_byte_en && !wr_bit_en)))
      |=> reg_q[LVL_POS] != $past(reg_q[LVL_POS]));

   // R7: accepted byte write sets the level regardless of wake strobes
   assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_guard && wr_byte_en) |=> reg_q[LVL_POS] == $past(wr_byte_data[LVL_POS]));
endmodule

// File: rtl/wkst_pin_steer.sv
module wkst_pin_steer
   import wkst_pkg::*;
#(
   parameter bit SEL_FIXED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_en,
   input  logic              out_lvl,
   input  logic              out_sel,
   input  logic [N_PINS-1:0] latch_i,
   output logic [N_PINS-1:0] pin_o
);
   localparam int SEL_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;

   initial begin
      assert (N_PINS == 2) else $error("select field is one bit wide");
   end

   logic [SEL_W-1:0] sel_idx;

   generate
      if (SEL_FIXED) begin : g_sel_fixed
         assign sel_idx = '0;
         logic unused_sel;
         assign unused_sel = out_sel;
      end else begin : g_sel_live
         assign sel_idx = SEL_W'(out_sel);
      end

      for (genvar p = 0; p < N_PINS; p++) begin : g_pin
         assign pin_o[p] = (out_en && (sel_idx == SEL_W'(p))) ? out_lvl : latch_i[p];
      end
   endgenerate

   // R8: enabled with select 0 drives the level on pin A only
   assert_pin_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && sel_idx == '0) |-> (pin_o[0] == out_lvl && pin_o[1] == latch_i[1]));

   // R10: disabled output passes both latches through
   assert_pass_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (pin_o == latch_i));
endmodule

// File: rtl/wkst_toggler.sv
module wkst_toggler
   import wkst_pkg::*;
#(
   parameter bit SEL_FIXED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte_en,
   input  logic [REG_W-1:0] wr_byte_data,
   input  logic             wr_bit_en,
   input  logic [IDX_W-1:0] wr_bit_idx,
   input  logic             wr_bit_val,
   input  logic             wr_guard,
   input  logic             stop_wake,
   input  logic             snooze_wake,
   input  logic             latch_a,
   input  logic             latch_b,
   output logic [REG_W-1:0] rd_data,
   output logic             pin_a,
   output logic             pin_b
);
   logic [REG_W-1:0]  reg_q;
   logic [N_PINS-1:0] pins;

   wkst_ctrl_reg #(.SEL_FIXED(SEL_FIXED)) u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_byte_en   (wr_byte_en),
      .wr_byte_data (wr_byte_data),
      .wr_bit_en    (wr_bit_en),
      .wr_bit_idx   (wr_bit_idx),
      .wr_bit_val   (wr_bit_val),
      .wr_guard     (wr_guard),
      .stop_wake    (stop_wake),
      .snooze_wake  (snooze_wake),
      .reg_q        (reg_q)
   );

   wkst_pin_steer #(.SEL_FIXED(SEL_FIXED)) u_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .out_en  (reg_q[EN_POS]),
      .out_lvl (reg_q[LVL_POS]),
      .out_sel (reg_q[SEL_POS]),
      .latch_i ({latch_b, latch_a}),
      .pin_o   (pins)
   );

   assign rd_data = reg_q;
   assign pin_a   = pins[0];
   assign pin_b   = pins[1];
endmodule

// File: tb/wkst_toggler_tb.sv
module wkst_toggler_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_byte_en = 1'b0;
   logic [7:0] wr_byte_data = '0;
   logic       wr_bit_en = 1'b0;
   logic [2:0] wr_bit_idx = '0;
   logic       wr_bit_val = 1'b0;
   logic       wr_guard = 1'b0;
   logic       stop_wake = 1'b0;
   logic       snooze_wake = 1'b0;
   logic       latch_a = 1'b1;
   logic       latch_b = 1'b0;
   logic [7:0] rd_data, f_rd;
   logic       pin_a, pin_b, f_pin_a, f_pin_b;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   wkst_toggler u_dut (
      .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
      .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
      .wr_guard(wr_guard), .stop_wake(stop_wake), .snooze_wake(snooze_wake),
      .latch_a(latch_a), .latch_b(latch_b), .rd_data(rd_data), .pin_a(pin_a), .pin_b(pin_b));

   wkst_toggler #(.SEL_FIXED(1'b1)) u_dut_fix (
      .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
      .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
      .wr_guard(wr_guard), .stop_wake(stop_wake), .snooze_wake(snooze_wake),
      .latch_a(latch_a), .latch_b(latch_b), .rd_data(f_rd), .pin_a(f_pin_a), .pin_b(f_pin_b));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus at the falling edge, let it clock, sample after.
   task automatic cycle(input logic be, input logic [7:0] bd, input logic bi,
                        input logic [2:0] idx, input logic bv,
                        input logic sw, input logic zw);
      @(negedge clk);
      wr_byte_en = be; wr_byte_data = bd; wr_bit_en = bi; wr_bit_idx = idx;
      wr_bit_val = bv; stop_wake = sw; snooze_wake = zw;
      @(negedge clk);
      wr_byte_en = 1'b0; wr_bit_en = 1'b0; stop_wake = 1'b0; snooze_wake = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] d);
      cycle(1'b1, d, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic wbit(input logic [2:0] idx, input logic v);
      cycle(1'b0, 8'h00, 1'b1, idx, v, 1'b0, 1'b0);
   endtask

   task automatic t_reset;
      check("R1 reset value", rd_data, 8'h00);
      check("R1 pins pass latches", {6'd0, pin_b, pin_a}, {6'd0, latch_b, latch_a});
   endtask

   task automatic t_byte;
      wbyte(8'hFF);
      check("R2 reserved read zero", rd_data, 8'h91);
      wbyte(8'h00);
      check("R2 clear", rd_data, 8'h00);
   endtask

   task automatic t_bit;
      wbit(3'd7, 1'b1);
      check("R3 bit 7 set", rd_data, 8'h80);
      wbit(3'd4, 1'b1);
      check("R3 bit 4 set", rd_data, 8'h90);
      wbit(3'd2, 1'b1);
      check("R3 reserved index ignored", rd_data, 8'h90);
      wbit(3'd7, 1'b0);
      check("R3 bit 7 clear", rd_data, 8'h10);
   endtask

   task automatic t_guard;
      @(negedge clk); wr_guard = 1'b1;
      wbyte(8'hFF);
      check("R4 guarded byte write", rd_data, 8'h10);
      wbit(3'd0, 1'b1);
      check("R4 guarded bit write", rd_data, 8'h10);
      @(negedge clk); wr_guard = 1'b0;
   endtask

   task automatic t_wake;
      wbyte(8'h80);
      @(negedge clk); latch_a = 1'b1; latch_b = 1'b1; #1;
      check("R8 pin A carries level 0", {6'd0, pin_b, pin_a}, 8'h02);
      cycle(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      check("R5 stop release inverts", rd_data, 8'h90);
      check("R8 pin A carries level 1", {6'd0, pin_b, pin_a}, 8'h03);
      cycle(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      check("R6 snooze to run inverts", rd_data, 8'h80);
      cycle(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1);
      check("R6 both strobes cancel", rd_data, 8'h80);
   endtask

   task automatic t_sel;
      wbyte(8'h91);
      @(negedge clk); latch_a = 1'b0; latch_b = 1'b0; #1;
      check("R9 pin B carries level, A latch", {6'd0, pin_b, pin_a}, 8'h02);
      cycle(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      check("R9 level after stop", rd_data, 8'h81);
      @(negedge clk); latch_a = 1'b1; #1;
      check("R9 pin B low, A latch", {6'd0, pin_b, pin_a}, 8'h01);
   endtask

   task automatic t_off;
      wbyte(8'h10);
      @(negedge clk); latch_a = 1'b0; latch_b = 1'b1; #1;
      check("R10 disabled pins 0/1", {6'd0, pin_b, pin_a}, 8'h02);
      @(negedge clk); latch_a = 1'b1; latch_b = 1'b0; #1;
      check("R10 disabled pins 1/0", {6'd0, pin_b, pin_a}, 8'h01);
      cycle(1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      check("R5 inverts while disabled", rd_data, 8'h00);
      check("R10 pins after wake", {6'd0, pin_b, pin_a}, 8'h01);
   endtask

   task automatic t_prio;
      cycle(1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      check("R7 byte write beats stop", rd_data, 8'h00);
      cycle(1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 1'b0, 1'b1);
      check("R7 bit write beats snooze", rd_data, 8'h10);
      cycle(1'b0, 8'h00, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0);
      check("R7 other-bit write keeps flip", rd_data, 8'h80);
      @(negedge clk); wr_guard = 1'b1;
      cycle(1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      check("R4 guarded write, wake still flips", rd_data, 8'h90);
      @(negedge clk); wr_guard = 1'b0;
   endtask

   task automatic t_collide;
      cycle(1'b1, 8'h80, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0);
      check("R11 byte write wins over bit", rd_data, 8'h80);
   endtask

   task automatic t_fixed;
      wbyte(8'hFF);
      check("R12 fixed select reads", f_rd, 8'h90);
      wbit(3'd0, 1'b1);
      check("R12 bit 0 write ignored", f_rd, 8'h90);
      @(negedge clk); latch_a = 1'b0; latch_b = 1'b0; #1;
      check("R12 level on pin A", {6'd0, f_pin_b, f_pin_a}, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_byte;
      t_bit;
      t_guard;
      t_wake;
      t_sel;
      t_off;
      t_prio;
      t_collide;
      t_fixed;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=complete");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule